// File: doc/BRIEF.md
# Bytewide Nonvolatile RAM Interface Emulator

This block is a clocked model of the control side of a bytewide parallel memory with active-low chip enable, write enable and output enable pins. Every pin is sampled on the system clock through a synchronizer. Each falling edge of chip enable that the block accepts opens one memory cycle. That edge captures the address. Any later address movement is ignored until the next accepted edge.

The write-enable level at that edge picks the cycle type. A high level starts a read. A low level starts a write, and during a write the block never drives the bus. A read turns into a write if write enable drops while chip enable is still low. The byte on the data pins is stored when write enable or chip enable rises, whichever comes first, and only once per cycle. The data bus is driven only for a read, only once the access time has run out, and only while chip enable and output enable are both low. At all other times the bus is released.

Once started, a cycle always counts out its full access time, even if chip enable rises early. Chip enable must then stay high for a precharge interval before the next cycle may start. A falling edge that comes too early is dropped and raises a sticky violation flag. Times are given in clock cycles. The storage depth follows the address width: the default of 10 bits gives 1024 bytes, and a width of 15 gives the full 32768 bytes.

Top module: `nvr_emu`

## Requirements
- R1: After reset the data bus is not driven (`dq_oe` = 0, `dq_out` = 0) and `viol` = 0.
- R2: An accepted chip-enable fall captures `addr`. Address changes later in the same cycle do not change which byte is read or written.
- R3: If `we_n` is low when an accepted chip-enable fall is sampled, the cycle is a write, and `dq_oe` stays 0 for the whole cycle whatever `oe_n` is.
- R4: A cycle started with `we_n` high behaves as a read and may drive the bus. When `we_n` then goes low while `ce_n` is low, the bus is released and the cycle becomes a write.
- R5: A write stores the `dq_in` value present when the first of `we_n` or `ce_n` rises. At most one byte is stored per cycle, so a second write-enable pulse in the same cycle is not stored.
- R6: `dq_oe` is 1 only in a read cycle, after ACC_CYC clock cycles of access, with `ce_n`, `oe_n` low and `we_n` high. While `dq_oe` is 1, `dq_out` holds the byte at the captured address. Otherwise `dq_out` = 0.
- R7: A chip-enable fall is accepted only after chip enable has been sampled high for at least PRE_CYC consecutive cycles. An earlier fall sets `viol`, which stays 1 until reset. The rejected fall captures no address, stores nothing and drives nothing.
- R8: If chip enable rises before the access time has elapsed, the cycle still counts out its full ACC_CYC access cycles. A new fall is accepted only when both the access count and the precharge count are complete.
- R9: All pins pass through two-flop synchronizers. With `oe_n` and `we_n` already settled, `dq_oe` first rises right after the (ACC_CYC+3)-th rising clock edge that samples `ce_n` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_n | input | 1 | Chip enable pin, active low, asynchronous |
| we_n | input | 1 | Write enable pin, active low, asynchronous |
| oe_n | input | 1 | Output enable pin, active low, asynchronous |
| addr | input | ADDR_W | Address pins |
| dq_in | input | DATA_W | Data bus as seen at the pins |
| dq_out | output | DATA_W | Read data for the bus, zero when not driven |
| dq_oe | output | 1 | Data bus drive enable |
| viol | output | 1 | Sticky flag for an early chip-enable fall |

## Verification
A behavioural reference model runs alongside the block and is compared with it on every clock. The stimulus covers several kinds of cycle:

- Reads whose address moves after the chip-enable edge show whether the address was captured at the edge.
- Writes ended by chip enable alone are compared with writes ended by write enable alone and with writes ended by both pins together. This shows whether the stored byte is taken from the first rising pin.
- A write-enable-controlled cycle with a second write pulse checks that the bus is released when the cycle turns into a write, and that only one byte is stored.
- Precharge gaps of exactly PRE_CYC cycles and of one cycle fewer, plus a cycle whose chip enable rises after a single cycle, check that the access count and the precharge count are each enforced.

// File: rtl/nvr_pkg.sv
// Shared types for the bytewide nonvolatile RAM emulator.
// Assumes: nothing beyond IEEE 1800-2017.
package nvr_pkg;

    // Whether a memory cycle is currently in progress.
    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_BUSY = 1'b1
    } phase_t;

    // Kind of the running memory cycle; a read may turn into a write.
    typedef enum logic {
        CK_READ  = 1'b0,
        CK_WRITE = 1'b1
    } kind_t;

endpackage

// File: rtl/nvr_sync.sv
// Multi-stage synchronizer for a bundle of asynchronous pins.
// Assumes: each bit is treated on its own; the bits of a bundle all pass
// through the same number of stages, so they keep their relative timing
// in clock cycles. RST_VAL gives the idle level each stage holds in reset.
module nvr_sync #(
    parameter int             W       = 1,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [STAGES-1:0][W-1:0] stg;

    generate
        if (STAGES == 1) begin : g_single
            // Single stage: one register captures the pins.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[0] <= RST_VAL;
                else        stg[0] <= d;
            end
        end else begin : g_chain
            // Shift chain: new sample enters stage 0, oldest leaves the top.
            always_ff @(posedge clk) begin
                if (!rst_n) stg <= {STAGES{RST_VAL}};
                else        stg <= {stg[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = stg[STAGES-1];

endmodule

// File: rtl/nvr_array.sv
// Byte storage: one synchronous write port, one combinational read port.
// Assumes: contents are not cleared by reset (nonvolatile model); the
// depth is 2**ADDR_W words of DATA_W bits.
module nvr_array #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Store one word when the controller commits a write.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    assign rd_data = mem[rd_addr];

endmodule

// File: rtl/nvr_ctrl.sv
// Cycle controller: detects chip-enable falls on synchronized pins, latches
// the address, times the access and precharge intervals, decides read or
// write, commits one write per cycle and gates the bus drive.
// Assumes: all inputs already synchronized to clk; ACC_CYC >= 1, PRE_CYC >= 1.
module nvr_ctrl
    import nvr_pkg::*;
#(
    parameter int ADDR_W  = 10,
    parameter int DATA_W  = 8,
    parameter int ACC_CYC = 7,
    parameter int PRE_CYC = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              s_ce,
    input  logic              s_we,
    input  logic              s_oe,
    input  logic [ADDR_W-1:0] s_addr,
    input  logic [DATA_W-1:0] s_dq,
    output logic              store,
    output logic [ADDR_W-1:0] cyc_addr,
    output logic [DATA_W-1:0] store_data,
    output logic              drive,
    output logic              viol
);

    localparam int             ACC_W   = $clog2(ACC_CYC + 1);
    localparam int             PRE_W   = $clog2(PRE_CYC + 1);
    localparam logic [ACC_W-1:0] ACC_LIM = ACC_W'(ACC_CYC);
    localparam logic [PRE_W-1:0] PRE_LIM = PRE_W'(PRE_CYC);

    logic             ce_d;
    phase_t           phase;
    kind_t            kind;
    logic [ACC_W-1:0] acc_cnt;
    logic [PRE_W-1:0] hi_cnt;
    logic             ended;
    logic             wdone;
    logic             ce_fall;
    logic             acc_done;
    logic             ready;
    logic             start;
    logic             busy;

    assign busy     = (phase == PH_BUSY);
    assign ce_fall  = ce_d & ~s_ce;
    assign acc_done = (acc_cnt == ACC_LIM);
    assign ready    = (!busy || acc_done) && (hi_cnt >= PRE_LIM);
    assign start    = ce_fall & ready;

    assign store      = busy && (kind == CK_WRITE) && !wdone && !ended && (s_we || s_ce);
    assign store_data = s_dq;
    assign drive      = busy && !ended && acc_done && !s_ce && !s_oe && s_we && (kind == CK_READ);

    // Previous chip-enable level for falling-edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) ce_d <= 1'b1;
        else        ce_d <= s_ce;
    end

    // Count consecutive chip-enable-high cycles, saturating at the precharge limit.
    always_ff @(posedge clk) begin
        if (!rst_n)                 hi_cnt <= PRE_LIM;
        else if (!s_ce)             hi_cnt <= '0;
        else if (hi_cnt != PRE_LIM) hi_cnt <= hi_cnt + 1'b1;
    end

    // Cycle phase and access timer; a cycle ends once timed out with chip enable high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= PH_IDLE;
            acc_cnt <= '0;
        end else if (start) begin
            phase   <= PH_BUSY;
            acc_cnt <= '0;
        end else if (busy) begin
            if (!acc_done)       acc_cnt <= acc_cnt + 1'b1;
            if (acc_done && s_ce) phase  <= PH_IDLE;
        end
    end

    // Cycle kind: set by write enable at the start, promoted to write on a later fall.
    always_ff @(posedge clk) begin
        if (!rst_n)                              kind <= CK_READ;
        else if (start)                          kind <= s_we ? CK_READ : CK_WRITE;
        else if (busy && !ended && !s_ce && !s_we) kind <= CK_WRITE;
    end

    // Mark that chip enable has risen in this cycle; no further bus activity.
    always_ff @(posedge clk) begin
        if (!rst_n)             ended <= 1'b0;
        else if (start)         ended <= 1'b0;
        else if (busy && s_ce)  ended <= 1'b1;
    end

    // Remember that this cycle has already committed its write.
    always_ff @(posedge clk) begin
        if (!rst_n)      wdone <= 1'b0;
        else if (start)  wdone <= 1'b0;
        else if (store)  wdone <= 1'b1;
    end

    // Address latch, loaded only by an accepted chip-enable fall.
    always_ff @(posedge clk) begin
        if (!rst_n)     cyc_addr <= '0;
        else if (start) cyc_addr <= s_addr;
    end

    // Sticky protocol-violation flag for a fall that arrives too early.
    always_ff @(posedge clk) begin
        if (!rst_n)                  viol <= 1'b0;
        else if (ce_fall && !ready)  viol <= 1'b1;
    end

    // R2
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !start) |=> $stable(cyc_addr));

    // R3
    write_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !s_we) |=> (kind == CK_WRITE));

    // R5
    one_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        store |=> !store);

    // R6
    drive_in_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drive |-> $past(busy));

    // R7
    bad_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_fall && !ready) |=> viol);

    // R7
    viol_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        viol |=> viol);

    // R8
    min_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !acc_done) |=> busy);

endmodule

// File: rtl/nvr_emu.sv
// Top of the bytewide nonvolatile RAM emulator: synchronizes the pins,
// runs the cycle controller and the byte array, and presents read data
// with a separate drive enable for an external tristate buffer.
// Assumes: pins may change at any time relative to clk; timing is in clk cycles.
module nvr_emu #(
    parameter int ADDR_W  = 10,
    parameter int DATA_W  = 8,
    parameter int ACC_CYC = 7,
    parameter int PRE_CYC = 6,
    parameter int SYNC_N  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] dq_in,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe,
    output logic              viol
);

    localparam int BUS_W = ADDR_W + DATA_W;

    logic [2:0]        ctl_s;
    logic [BUS_W-1:0]  bus_s;
    logic              store;
    logic              drive;
    logic [ADDR_W-1:0] cyc_addr;
    logic [DATA_W-1:0] store_data;
    logic [DATA_W-1:0] rd_data;

    nvr_sync #(.W(3), .STAGES(SYNC_N), .RST_VAL(3'b111)) u_ctl_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({ce_n, we_n, oe_n}),
        .q     (ctl_s)
    );

    nvr_sync #(.W(BUS_W), .STAGES(SYNC_N), .RST_VAL('0)) u_bus_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({addr, dq_in}),
        .q     (bus_s)
    );

    nvr_ctrl #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .ACC_CYC (ACC_CYC),
        .PRE_CYC (PRE_CYC)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .s_ce       (ctl_s[2]),
        .s_we       (ctl_s[1]),
        .s_oe       (ctl_s[0]),
        .s_addr     (bus_s[BUS_W-1:DATA_W]),
        .s_dq       (bus_s[DATA_W-1:0]),
        .store      (store),
        .cyc_addr   (cyc_addr),
        .store_data (store_data),
        .drive      (drive),
        .viol       (viol)
    );

    nvr_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
        .clk     (clk),
        .wr_en   (store),
        .wr_addr (cyc_addr),
        .wr_data (store_data),
        .rd_addr (cyc_addr),
        .rd_data (rd_data)
    );

    assign dq_oe  = drive;
    assign dq_out = drive ? rd_data : '0;

endmodule

// File: tb/nvr_emu_test.sv
`timescale 1ns/1ps
// Bench for nvr_emu: a behavioural reference model is compared every clock,
// and directed scenarios check each requirement at known cycles.
module nvr_emu_test;

    localparam int AW  = 10;
    localparam int DW  = 8;
    localparam int ACC = 7;
    localparam int PRE = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] dq_in = '0;
    logic [DW-1:0] dq_out;
    logic          dq_oe;
    logic          viol;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    nvr_emu #(.ADDR_W(AW), .DATA_W(DW), .ACC_CYC(ACC), .PRE_CYC(PRE)) uut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe), .viol(viol)
    );

    always #2 clk = ~clk;

    // ---------------- reference model ----------------
    typedef struct packed {
        logic          ce;
        logic          we;
        logic          oe;
        logic [AW-1:0] a;
        logic [DW-1:0] d;
    } pins_t;

    localparam pins_t IDLE_PINS = '{ce: 1'b1, we: 1'b1, oe: 1'b1, a: '0, d: '0};

    pins_t h1 = IDLE_PINS, h2 = IDLE_PINS;
    bit    h3ce = 1'b1;
    int    m_acc = 0, m_hi = PRE, m_addr = 0;
    bit    m_busy = 0, m_wr = 0, m_wdone = 0, m_ended = 0, m_viol = 0;
    logic [DW-1:0] mem_m [int];

    always @(posedge clk) begin
        if (!rst_n) begin
            h1 = IDLE_PINS; h2 = IDLE_PINS; h3ce = 1'b1;
            m_acc = 0; m_hi = PRE; m_addr = 0;
            m_busy = 0; m_wr = 0; m_wdone = 0; m_ended = 0; m_viol = 0;
        end else begin
            bit fall, ok, st;
            fall = !h2.ce && h3ce;
            ok   = (!m_busy || m_acc >= ACC) && (m_hi >= PRE);
            st   = m_busy && m_wr && !m_wdone && !m_ended && (h2.we || h2.ce);
            if (st) mem_m[m_addr] = h2.d;
            if (fall && !ok) m_viol = 1;
            if (fall && ok) begin
                m_busy = 1; m_acc = 0; m_wr = !h2.we; m_ended = 0; m_wdone = 0;
                m_addr = int'(h2.a);
            end else if (m_busy) begin
                if (st) m_wdone = 1;
                if (!m_ended && !h2.ce && !h2.we) m_wr = 1;
                if (h2.ce) m_ended = 1;
                if (m_acc >= ACC && h2.ce) m_busy = 0;
                if (m_acc < ACC) m_acc++;
            end
            m_hi = h2.ce ? ((m_hi < PRE) ? m_hi + 1 : PRE) : 0;
            h3ce = h2.ce;
            h2 = h1;
            h1 = '{ce: ce_n, we: we_n, oe: oe_n, a: addr, d: dq_in};
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Per-clock comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            bit e_oe;
            e_oe = m_busy && !m_ended && (m_acc >= ACC) && !h2.ce && !h2.oe && h2.we && !m_wr;
            chk(dq_oe == e_oe, "R6 drive enable vs model", int'(dq_oe), int'(e_oe));
            if (!e_oe)
                chk(dq_out == '0, "R6 idle bus value", int'(dq_out), 0);
            else if (mem_m.exists(m_addr))
                chk(dq_out == mem_m[m_addr], "R2 read data vs model", int'(dq_out), int'(mem_m[m_addr]));
            chk(viol == m_viol, "R7 violation flag vs model", int'(viol), int'(m_viol));
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
        cyc(3);
        rst_n = 1'b1;
        cyc(2);
    endtask

    task automatic idle(input int n);
        ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
        cyc(n);
    endtask

    // Write started with write enable low; optionally oe low to prove no drive.
    task automatic write_ce(input logic [AW-1:0] a, input logic [DW-1:0] d);
        bit seen = 0;
        addr = a; dq_in = d; we_n = 1'b0; oe_n = 1'b0; ce_n = 1'b0;
        for (int i = 0; i < 10; i++) begin
            cyc(1);
            if (dq_oe) seen = 1;
        end
        ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
        cyc(2);
        chk(!seen, "R3 no drive in write cycle", int'(seen), 0);
        idle(PRE + 2);
    endtask

    // Read with the address moved after the chip-enable fall.
    task automatic read_chk(input logic [AW-1:0] a, input logic [DW-1:0] e, input string req);
        addr = a; we_n = 1'b1; oe_n = 1'b0; ce_n = 1'b0;
        cyc(1);
        addr = ~a;
        cyc(12);
        chk(dq_oe == 1'b1, req, int'(dq_oe), 1);
        chk(dq_out == e, req, int'(dq_out), int'(e));
        idle(PRE + 2);
    endtask

    initial begin
        do_reset();
        // R1: reset state
        chk(dq_oe == 1'b0, "R1 reset drive enable", int'(dq_oe), 0);
        chk(dq_out == '0, "R1 reset bus value", int'(dq_out), 0);
        chk(viol == 1'b0, "R1 reset violation", int'(viol), 0);

        // R3 R5 write by both pins rising, R2 readback with moved address
        write_ce(10'h155, 8'hA5);
        read_chk(10'h155, 8'hA5, "R2 read after latched address");
        write_ce(10'h2AA, 8'h3C);
        read_chk(10'h2AA, 8'h3C, "R2 second address");

        // R4: read turned into write by a later write-enable fall
        addr = 10'h0F0; dq_in = 8'h00; we_n = 1'b1; oe_n = 1'b0; ce_n = 1'b0;
        cyc(12);
        chk(dq_oe == 1'b1, "R4 driven as read before write enable", int'(dq_oe), 1);
        we_n = 1'b0; dq_in = 8'hEE;
        cyc(4);
        chk(dq_oe == 1'b0, "R4 released after write enable falls", int'(dq_oe), 0);
        dq_in = 8'h77;
        cyc(2);
        we_n = 1'b1;
        cyc(2);
        dq_in = 8'h99;
        cyc(3);
        chk(dq_oe == 1'b0, "R4 stays released as write", int'(dq_oe), 0);
        idle(PRE + 2);
        read_chk(10'h0F0, 8'h77, "R5 data at write-enable rise");

        // R5: chip enable rises first while write enable stays low
        addr = 10'h010; dq_in = 8'hC3; we_n = 1'b0; oe_n = 1'b1; ce_n = 1'b0;
        cyc(10);
        ce_n = 1'b1;
        cyc(2);
        dq_in = 8'h00;
        cyc(2);
        idle(PRE + 2);
        read_chk(10'h010, 8'hC3, "R5 data at chip-enable rise");

        // R5: second write pulse in the same cycle is not stored
        addr = 10'h011; we_n = 1'b1; oe_n = 1'b1; ce_n = 1'b0;
        cyc(3);
        dq_in = 8'h11; we_n = 1'b0;
        cyc(3);
        we_n = 1'b1;
        cyc(3);
        dq_in = 8'h22; we_n = 1'b0;
        cyc(3);
        we_n = 1'b1;
        cyc(3);
        idle(PRE + 2);
        read_chk(10'h011, 8'h11, "R5 only one store per cycle");

        // R9 R6: exact drive latency from the chip-enable pin
        addr = 10'h155; we_n = 1'b1; oe_n = 1'b0; ce_n = 1'b0;
        cyc(ACC + 2);
        chk(dq_oe == 1'b0, "R9 not driven before access time", int'(dq_oe), 0);
        cyc(1);
        chk(dq_oe == 1'b1, "R9 driven at access time", int'(dq_oe), 1);
        idle(PRE + 2);

        // R6: output enable high keeps the bus released
        addr = 10'h2AA; we_n = 1'b1; oe_n = 1'b1; ce_n = 1'b0;
        cyc(12);
        chk(dq_oe == 1'b0, "R6 output enable high", int'(dq_oe), 0);
        oe_n = 1'b0;
        cyc(3);
        chk(dq_oe == 1'b1, "R6 output enable low", int'(dq_oe), 1);
        chk(dq_out == 8'h3C, "R6 data when driven", int'(dq_out), 'h3C);

        // R7: precharge of exactly PRE cycles is accepted
        ce_n = 1'b1;
        cyc(PRE);
        addr = 10'h155; ce_n = 1'b0;
        cyc(4);
        chk(viol == 1'b0, "R7 exact precharge accepted", int'(viol), 0);
        cyc(10);
        chk(dq_out == 8'hA5, "R7 accepted cycle reads", int'(dq_out), 'hA5);
        idle(PRE + 2);

        // R7: one cycle short of precharge sets the sticky flag and is ignored
        do_reset();
        addr = 10'h155; we_n = 1'b1; oe_n = 1'b1; ce_n = 1'b0;
        cyc(12);
        ce_n = 1'b1;
        cyc(PRE - 1);
        addr = 10'h2AA; oe_n = 1'b0; ce_n = 1'b0;
        cyc(4);
        chk(viol == 1'b1, "R7 short precharge flagged", int'(viol), 1);
        cyc(10);
        chk(dq_oe == 1'b0, "R7 rejected fall not driven", int'(dq_oe), 0);
        idle(PRE + 2);
        read_chk(10'h2AA, 8'h3C, "R7 next legal cycle works");
        chk(viol == 1'b1, "R7 flag is sticky", int'(viol), 1);

        // R8: early rise, access and precharge both complete -> accepted
        do_reset();
        addr = 10'h155; we_n = 1'b1; oe_n = 1'b1; ce_n = 1'b0;
        cyc(1);
        ce_n = 1'b1;
        cyc(ACC);
        oe_n = 1'b0; ce_n = 1'b0;
        cyc(4);
        chk(viol == 1'b0, "R8 restart after full access", int'(viol), 0);
        cyc(12);
        chk(dq_out == 8'hA5, "R8 restarted cycle reads", int'(dq_out), 'hA5);
        idle(PRE + 2);

        // R8: early rise, precharge met but access not finished -> violation
        do_reset();
        addr = 10'h155; we_n = 1'b1; oe_n = 1'b1; ce_n = 1'b0;
        cyc(1);
        ce_n = 1'b1;
        cyc(ACC - 1);
        ce_n = 1'b0;
        cyc(4);
        chk(viol == 1'b1, "R8 restart before access done", int'(viol), 1);
        idle(PRE + 2);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule